// File: doc/BRIEF.md
# Pre-Trade Risk Limit Checker

This block sits on the outgoing order path. Each new order request is tested against five limits before it can go on to be serialized: order size, prospective net position, loss booked in the current minute, profit and loss for the day, and the number of orders passed in the current second. One clock after a request arrives, the block returns a registered decision: pass or reject, with a reason code. A cancel request always passes and is not tested against any limit.

The block keeps its own state, updated from fill reports. For every symbol it holds a long quantity and a short quantity, and the net position is their difference. It also keeps a signed day profit-and-loss total, a loss total for the current minute, and a count of orders passed in the current second. Two tick inputs, one pulsed each second and one pulsed each minute, open new windows for the rate count and the minute loss.

Top module: `risk_gate`

## Requirements
- R1: A decision (`dec_valid` high for one cycle) appears on the clock edge after the edge that samples `req_valid`. With no request, `dec_valid` stays low. `dec_pass` is 1 exactly when `dec_reason` is 0.
- R2: A request with `req_cancel` set passes with reason 0 whatever the limits and state are. It is not added to the per-second order count.
- R3: An order whose `req_qty` is greater than `lim_order_qty` is rejected with reason 1.
- R4: Side 0 is buy and side 1 is sell. A buy fill adds its quantity to the symbol's long count, a sell fill adds it to the short count, and each count saturates at all ones. The net position is long minus short. An order is rejected with reason 2 when |net + qty| (buy) or |net - qty| (sell) is greater than `lim_position`.
- R5: Only fills with negative P&L add their magnitude to the minute loss, which saturates. An order is rejected with reason 3 when the minute loss is greater than `lim_minute_loss`. `tick_min` clears the minute loss.
- R6: Every fill's signed P&L is added to a saturating day total. An order is rejected with reason 4 when that total is below -`lim_daily_loss`.
- R7: Each order that passes, and only such an order, increments the per-second count. An order is rejected with reason 5 when the count is already greater than or equal to `lim_rate`. `tick_sec` clears the count.
- R8: When several checks fail, the reason given is the first failing one in the order size (1), position (2), minute loss (3), day loss (4), rate (5).
- R9: After reset there is no decision, every position count, the loss totals and the rate count are zero, and an order within every limit passes.
- R10: A tick in the same cycle as a request already applies to that request. A fill in the same cycle as a request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Order request present this cycle |
| req_cancel | input | 1 | Request is a cancel |
| req_sym | input | SYM_W | Symbol index of the request |
| req_side | input | 1 | 0 buy, 1 sell |
| req_qty | input | QTY_W | Requested quantity |
| fill_valid | input | 1 | Fill report present this cycle |
| fill_sym | input | SYM_W | Symbol index of the fill |
| fill_side | input | 1 | 0 buy, 1 sell |
| fill_qty | input | QTY_W | Filled quantity |
| fill_pnl | input | PNL_W | Signed P&L of the fill |
| lim_order_qty | input | QTY_W | Largest allowed order quantity |
| lim_position | input | POS_W | Largest allowed absolute net position |
| lim_minute_loss | input | PNL_W | Largest allowed loss within the current minute |
| lim_daily_loss | input | PNL_W | Largest allowed loss for the day |
| lim_rate | input | RATE_W | Orders allowed to pass per second |
| tick_sec | input | 1 | One-cycle pulse at each second boundary |
| tick_min | input | 1 | One-cycle pulse at each minute boundary |
| dec_valid | output | 1 | Decision present |
| dec_pass | output | 1 | Request passed |
| dec_reason | output | 3 | Reject reason, 0 when passed |

## Verification
The bench builds the block with four symbols, 4-bit quantities, 6-bit position counts, 8-bit P&L and a 3-bit rate count. At these sizes it can sweep every order quantity on both sides against the size and position limits. The position counts can also be driven into saturation at 63, and the rate limit can be hit and its edge crossed within a handful of orders. A long pseudo-random run then mixes requests, fills, ticks and changing limits, and checks each decision against an arithmetic model of the requirements.

// File: rtl/risk_pkg.sv
package risk_pkg;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_SIZE    = 3'd1,
        RSN_POS     = 3'd2,
        RSN_MINLOSS = 3'd3,
        RSN_DAYLOSS = 3'd4,
        RSN_RATE    = 3'd5
    } reason_e;

    localparam logic SIDE_BUY = 1'b0;

    typedef struct packed {
        logic    valid;
        logic    pass;
        reason_e reason;
    } decision_t;

endpackage

// File: rtl/risk_book.sv
module risk_book #(
    parameter int SYM_W = 3,
    parameter int QTY_W = 16,
    parameter int POS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    input  logic [SYM_W-1:0]        fill_sym,
    input  logic                    fill_side,
    input  logic [QTY_W-1:0]        fill_qty,
    input  logic [SYM_W-1:0]        rd_sym,
    output logic signed [POS_W:0]   rd_net
);
    import risk_pkg::*;

    localparam int NSYM = 1 << SYM_W;

    typedef struct packed {
        logic [POS_W-1:0] long_qty;
        logic [POS_W-1:0] short_qty;
    } slot_t;

    logic signed [POS_W:0] net_of [NSYM];

    for (genvar g = 0; g < NSYM; g++) begin : g_slot
        slot_t          slot_d;
        slot_t          slot_q;
        logic           hit;
        logic [POS_W-1:0] base;
        logic [POS_W:0] sum;

        always_comb begin
            slot_d = slot_q;
            hit    = fill_valid && (fill_sym == SYM_W'(g));
            base   = (fill_side == SIDE_BUY) ? slot_q.long_qty : slot_q.short_qty;
            sum    = {1'b0, base} + (POS_W+1)'(fill_qty);
            if (hit) begin
                if (fill_side == SIDE_BUY) begin
                    slot_d.long_qty = sum[POS_W] ? '1 : sum[POS_W-1:0];
                end else begin
                    slot_d.short_qty = sum[POS_W] ? '1 : sum[POS_W-1:0];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign net_of[g] = $signed({1'b0, slot_q.long_qty}) - $signed({1'b0, slot_q.short_qty});
    end

    assign rd_net = net_of[rd_sym];

endmodule

// File: rtl/risk_window.sv
module risk_window #(
    parameter int PNL_W  = 32,
    parameter int RATE_W = 16,
    localparam int DAY_W  = PNL_W + 8,
    localparam int LOSS_W = PNL_W + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    input  logic signed [PNL_W-1:0] fill_pnl,
    input  logic                    tick_sec,
    input  logic                    tick_min,
    input  logic                    order_passed,
    output logic [LOSS_W-1:0]       loss_now,
    output logic [RATE_W-1:0]       rate_now,
    output logic signed [DAY_W-1:0] day_now
);

    typedef struct packed {
        logic signed [DAY_W-1:0] day;
        logic [LOSS_W-1:0]       loss;
        logic [RATE_W-1:0]       rate;
    } win_t;

    win_t st_d, st_q;

    logic signed [LOSS_W-1:0] pnl_x;
    logic [LOSS_W-1:0]        loss_mag;
    logic [LOSS_W:0]          loss_sum;
    logic signed [DAY_W:0]    day_base;
    logic signed [DAY_W:0]    day_add;
    logic signed [DAY_W:0]    day_sum;
    logic [RATE_W:0]          rate_sum;

    always_comb begin
        st_d     = st_q;
        loss_now = tick_min ? '0 : st_q.loss;
        rate_now = tick_sec ? '0 : st_q.rate;
        day_now  = st_q.day;

        pnl_x    = LOSS_W'(fill_pnl);
        loss_mag = (fill_valid && (fill_pnl < 0)) ? unsigned'(-pnl_x) : '0;
        loss_sum = {1'b0, loss_now} + {1'b0, loss_mag};
        st_d.loss = loss_sum[LOSS_W] ? '1 : loss_sum[LOSS_W-1:0];

        day_base = (DAY_W+1)'(st_q.day);
        day_add  = '0;
        if (fill_valid) begin
            day_add = (DAY_W+1)'(fill_pnl);
        end
        day_sum = day_base + day_add;
        if (day_sum[DAY_W] != day_sum[DAY_W-1]) begin
            st_d.day = day_sum[DAY_W] ? {1'b1, {(DAY_W-1){1'b0}}} : {1'b0, {(DAY_W-1){1'b1}}};
        end else begin
            st_d.day = day_sum[DAY_W-1:0];
        end

        rate_sum  = {1'b0, rate_now} + (RATE_W+1)'(order_passed);
        st_d.rate = rate_sum[RATE_W] ? '1 : rate_sum[RATE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/risk_judge.sv
module risk_judge #(
    parameter int QTY_W  = 16,
    parameter int POS_W  = 24,
    parameter int PNL_W  = 32,
    parameter int RATE_W = 16,
    localparam int DAY_W  = PNL_W + 8,
    localparam int LOSS_W = PNL_W + 4,
    localparam int PRO_W  = POS_W + 2
) (
    input  logic                    req_side,
    input  logic [QTY_W-1:0]        req_qty,
    input  logic signed [POS_W:0]   net,
    input  logic [LOSS_W-1:0]       loss_now,
    input  logic signed [DAY_W-1:0] day_now,
    input  logic [RATE_W-1:0]       rate_now,
    input  logic [QTY_W-1:0]        lim_order_qty,
    input  logic [POS_W-1:0]        lim_position,
    input  logic [PNL_W-1:0]        lim_minute_loss,
    input  logic [PNL_W-1:0]        lim_daily_loss,
    input  logic [RATE_W-1:0]       lim_rate,
    output risk_pkg::reason_e       reason
);
    import risk_pkg::*;

    logic signed [PRO_W-1:0] qty_x;
    logic signed [PRO_W-1:0] net_x;
    logic signed [PRO_W-1:0] pro;
    logic [PRO_W-1:0]        pro_mag;
    logic signed [DAY_W-1:0] day_floor;
    logic f_size, f_pos, f_min, f_day, f_rate;

    always_comb begin
        qty_x     = $signed({{(PRO_W-QTY_W){1'b0}}, req_qty});
        net_x     = PRO_W'(net);
        pro       = (req_side == SIDE_BUY) ? (net_x + qty_x) : (net_x - qty_x);
        pro_mag   = pro[PRO_W-1] ? unsigned'(-pro) : unsigned'(pro);
        day_floor = -$signed({{(DAY_W-PNL_W){1'b0}}, lim_daily_loss});

        f_size = req_qty > lim_order_qty;
        f_pos  = pro_mag > {2'b00, lim_position};
        f_min  = loss_now > {{(LOSS_W-PNL_W){1'b0}}, lim_minute_loss};
        f_day  = day_now < day_floor;
        f_rate = rate_now >= lim_rate;

        if (f_size) begin
            reason = RSN_SIZE;
        end else if (f_pos) begin
            reason = RSN_POS;
        end else if (f_min) begin
            reason = RSN_MINLOSS;
        end else if (f_day) begin
            reason = RSN_DAYLOSS;
        end else if (f_rate) begin
            reason = RSN_RATE;
        end else begin
            reason = RSN_NONE;
        end
    end

endmodule

// File: rtl/risk_gate.sv
module risk_gate #(
    parameter int SYM_W  = 3,
    parameter int QTY_W  = 16,
    parameter int POS_W  = 24,
    parameter int PNL_W  = 32,
    parameter int RATE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_cancel,
    input  logic [SYM_W-1:0]        req_sym,
    input  logic                    req_side,
    input  logic [QTY_W-1:0]        req_qty,
    input  logic                    fill_valid,
    input  logic [SYM_W-1:0]        fill_sym,
    input  logic                    fill_side,
    input  logic [QTY_W-1:0]        fill_qty,
    input  logic signed [PNL_W-1:0] fill_pnl,
    input  logic [QTY_W-1:0]        lim_order_qty,
    input  logic [POS_W-1:0]        lim_position,
    input  logic [PNL_W-1:0]        lim_minute_loss,
    input  logic [PNL_W-1:0]        lim_daily_loss,
    input  logic [RATE_W-1:0]       lim_rate,
    input  logic                    tick_sec,
    input  logic                    tick_min,
    output logic                    dec_valid,
    output logic                    dec_pass,
    output logic [2:0]              dec_reason
);
    import risk_pkg::*;

    localparam int DAY_W  = PNL_W + 8;
    localparam int LOSS_W = PNL_W + 4;

    logic signed [POS_W:0]   net;
    logic [LOSS_W-1:0]       loss_now;
    logic [RATE_W-1:0]       rate_now;
    logic signed [DAY_W-1:0] day_now;
    reason_e                 judged;
    logic                    order_passed;
    decision_t               dec_d, dec_q;

    risk_book #(.SYM_W(SYM_W), .QTY_W(QTY_W), .POS_W(POS_W)) u_book (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_sym   (fill_sym),
        .fill_side  (fill_side),
        .fill_qty   (fill_qty),
        .rd_sym     (req_sym),
        .rd_net     (net)
    );

    risk_window #(.PNL_W(PNL_W), .RATE_W(RATE_W)) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid   (fill_valid),
        .fill_pnl     (fill_pnl),
        .tick_sec     (tick_sec),
        .tick_min     (tick_min),
        .order_passed (order_passed),
        .loss_now     (loss_now),
        .rate_now     (rate_now),
        .day_now      (day_now)
    );

    risk_judge #(.QTY_W(QTY_W), .POS_W(POS_W), .PNL_W(PNL_W), .RATE_W(RATE_W)) u_judge (
        .req_side        (req_side),
        .req_qty         (req_qty),
        .net             (net),
        .loss_now        (loss_now),
        .day_now         (day_now),
        .rate_now        (rate_now),
        .lim_order_qty   (lim_order_qty),
        .lim_position    (lim_position),
        .lim_minute_loss (lim_minute_loss),
        .lim_daily_loss  (lim_daily_loss),
        .lim_rate        (lim_rate),
        .reason          (judged)
    );

    always_comb begin
        dec_d        = '0;
        dec_d.valid  = req_valid;
        dec_d.reason = RSN_NONE;
        if (req_valid) begin
            if (req_cancel) begin
                dec_d.pass = 1'b1;
            end else begin
                dec_d.reason = judged;
                dec_d.pass   = (judged == RSN_NONE);
            end
        end
        order_passed = req_valid && !req_cancel && (judged == RSN_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_pass   = dec_q.pass;
    assign dec_reason = dec_q.reason;

endmodule

// File: rtl/risk_gate_checker.sv
module risk_gate_checker #(
    parameter int QTY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_cancel,
    input logic [QTY_W-1:0] req_qty,
    input logic [QTY_W-1:0] lim_order_qty,
    input logic             dec_valid,
    input logic             dec_pass,
    input logic [2:0]       dec_reason
);

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);

    assert_pass_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_pass == (dec_reason == 3'd0)));

    assert_cancel_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cancel) |=> (dec_pass && dec_reason == 3'd0));

    assert_size_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_cancel && (req_qty > lim_order_qty)) |=> (!dec_pass && dec_reason == 3'd1));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_pass && dec_reason == 3'd0));

endmodule

bind risk_gate risk_gate_checker #(.QTY_W(QTY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_cancel    (req_cancel),
    .req_qty       (req_qty),
    .lim_order_qty (lim_order_qty),
    .dec_valid     (dec_valid),
    .dec_pass      (dec_pass),
    .dec_reason    (dec_reason)
);

// File: tb/risk_gate_test.sv
module risk_gate_test;

    localparam int SYM_W  = 2;
    localparam int QTY_W  = 4;
    localparam int POS_W  = 6;
    localparam int PNL_W  = 8;
    localparam int RATE_W = 3;
    localparam int NSYM   = 1 << SYM_W;
    localparam int POS_MAX  = (1 << POS_W) - 1;
    localparam int LOSS_MAX = (1 << (PNL_W + 4)) - 1;
    localparam int DAY_MAX  = (1 << (PNL_W + 7)) - 1;
    localparam int RATE_MAX = (1 << RATE_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_cancel = 0, req_side = 0;
    logic [SYM_W-1:0] req_sym = '0;
    logic [QTY_W-1:0] req_qty = '0;
    logic fill_valid = 0, fill_side = 0;
    logic [SYM_W-1:0] fill_sym = '0;
    logic [QTY_W-1:0] fill_qty = '0;
    logic signed [PNL_W-1:0] fill_pnl = '0;
    logic [QTY_W-1:0]  lim_order_qty = '1;
    logic [POS_W-1:0]  lim_position = '1;
    logic [PNL_W-1:0]  lim_minute_loss = '1;
    logic [PNL_W-1:0]  lim_daily_loss = '1;
    logic [RATE_W-1:0] lim_rate = '1;
    logic tick_sec = 0, tick_min = 0;
    logic dec_valid, dec_pass;
    logic [2:0] dec_reason;

    always #2 clk = ~clk;

    risk_gate #(.SYM_W(SYM_W), .QTY_W(QTY_W), .POS_W(POS_W), .PNL_W(PNL_W), .RATE_W(RATE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cancel(req_cancel), .req_sym(req_sym),
        .req_side(req_side), .req_qty(req_qty),
        .fill_valid(fill_valid), .fill_sym(fill_sym), .fill_side(fill_side),
        .fill_qty(fill_qty), .fill_pnl(fill_pnl),
        .lim_order_qty(lim_order_qty), .lim_position(lim_position),
        .lim_minute_loss(lim_minute_loss), .lim_daily_loss(lim_daily_loss),
        .lim_rate(lim_rate), .tick_sec(tick_sec), .tick_min(tick_min),
        .dec_valid(dec_valid), .dec_pass(dec_pass), .dec_reason(dec_reason)
    );

    int vectors = 0;
    int fails = 0;
    int m_long [NSYM];
    int m_short [NSYM];
    int m_day = 0, m_loss = 0, m_rate = 0;
    logic [31:0] rng = 32'h1234_5679;

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
    end

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic next_rng;
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    // Caller is at a falling edge. Drives one cycle, checks the decision at the next falling edge.
    task automatic step(input string tag, input bit rv, input bit rc, input int rs, input bit rside,
                        input int rq, input bit fv, input int fs, input bit fside, input int fq,
                        input int fp, input bit ts, input bit tm);
        int loss_e, rate_e, net, pro, exp_r;
        req_valid = rv; req_cancel = rc; req_sym = SYM_W'(rs); req_side = rside; req_qty = QTY_W'(rq);
        fill_valid = fv; fill_sym = SYM_W'(fs); fill_side = fside; fill_qty = QTY_W'(fq);
        fill_pnl = PNL_W'(fp); tick_sec = ts; tick_min = tm;
        loss_e = tm ? 0 : m_loss;
        rate_e = ts ? 0 : m_rate;
        net = m_long[rs] - m_short[rs];
        pro = rside ? net - rq : net + rq;
        if (pro < 0) pro = -pro;
        if (rc)                              exp_r = 0;
        else if (rq > int'(lim_order_qty))   exp_r = 1;
        else if (pro > int'(lim_position))   exp_r = 2;
        else if (loss_e > int'(lim_minute_loss)) exp_r = 3;
        else if (m_day < -int'(lim_daily_loss))  exp_r = 4;
        else if (rate_e >= int'(lim_rate))   exp_r = 5;
        else                                 exp_r = 0;
        @(negedge clk);
        vectors++;
        if (rv) begin
            if (!(dec_valid === 1'b1 && dec_pass === (exp_r == 0) && dec_reason === 3'(exp_r))) begin
                fails++;
                $display("FAIL %s: actual valid=%0b pass=%0b reason=%0d expected valid=1 pass=%0b reason=%0d",
                         tag, dec_valid, dec_pass, dec_reason, exp_r == 0, exp_r);
            end
        end else if (dec_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 %s: actual valid=%0b expected valid=0", tag, dec_valid);
        end
        m_loss = clampi(loss_e + ((fv && fp < 0) ? -fp : 0), 0, LOSS_MAX);
        if (fv) begin
            m_day = clampi(m_day + fp, -DAY_MAX - 1, DAY_MAX);
            if (fside) m_short[fs] = clampi(m_short[fs] + fq, 0, POS_MAX);
            else       m_long[fs]  = clampi(m_long[fs] + fq, 0, POS_MAX);
        end
        m_rate = clampi(rate_e + ((rv && !rc && exp_r == 0) ? 1 : 0), 0, RATE_MAX);
        req_valid = 0; fill_valid = 0; tick_sec = 0; tick_min = 0; req_cancel = 0;
    endtask

    task automatic order(input string tag, input bit rc, input int rs, input bit rside, input int rq,
                         input bit ts, input bit tm);
        step(tag, 1, rc, rs, rside, rq, 0, 0, 0, 0, 0, ts, tm);
    endtask

    task automatic fill(input int fs, input bit fside, input int fq, input int fp);
        step("R1 idle", 0, 0, 0, 0, 0, 1, fs, fside, fq, fp, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < NSYM; i++) begin m_long[i] = 0; m_short[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: no decision out of reset
        vectors++;
        if (dec_valid !== 1'b0 || dec_pass !== 1'b0 || dec_reason !== 3'd0) begin
            fails++;
            $display("FAIL R9: actual valid=%0b pass=%0b reason=%0d expected 0 0 0", dec_valid, dec_pass, dec_reason);
        end
        order("R9 clean state", 0, 3, 1, 15, 0, 0);

        // R3: every quantity, both sides, size limit 7
        lim_order_qty = 4'd7;
        for (int q = 0; q < 16; q++)
            for (int s = 0; s < 2; s++)
                order("R3 size sweep", 0, 1, s[0], q, 1, 0);

        // R2: cancels pass even when size and rate fail, and are not counted
        lim_rate = 3'd0;
        order("R2 cancel", 1, 2, 0, 15, 0, 0);
        lim_rate = 3'd2;
        order("R2 cancel", 1, 2, 1, 3, 1, 0);
        order("R2 cancel", 1, 2, 1, 3, 0, 0);
        order("R7 after cancels", 0, 2, 0, 1, 0, 0);
        order("R7 after cancels", 0, 2, 0, 1, 0, 0);
        order("R7 rate hit", 0, 2, 0, 1, 0, 0);
        lim_rate = '1; lim_order_qty = '1;

        // R4: build positions per symbol, sweep qty on both sides
        lim_position = 6'd10;
        for (int s = 0; s < NSYM; s++) begin
            fill(s, 0, 3 * s + 1, 0);
            fill(s, 1, 4, 0);
            for (int q = 0; q < 16; q++)
                for (int d = 0; d < 2; d++)
                    order("R4 position sweep", 0, s, d[0], q, 1, 0);
        end
        // R4: saturation of the long count at 63
        for (int k = 0; k < 6; k++) fill(0, 0, 15, 0);
        lim_position = '1;
        order("R4 saturated long", 0, 0, 0, 15, 1, 0);
        order("R4 saturated long", 0, 0, 1, 15, 1, 0);
        for (int k = 0; k < 4; k++) fill(0, 1, 15, 0);
        lim_position = 6'd10;
        // R10: fill and request in the same cycle; fill not seen by this request
        step("R10 same-cycle fill", 1, 0, 1, 0, 6, 1, 1, 0, 8, 0, 1, 0);
        order("R10 fill now seen", 0, 1, 0, 6, 1, 0);
        lim_position = '1;

        // R5: minute loss window
        lim_minute_loss = 8'd100;
        fill(2, 0, 0, 100);
        order("R5 positive pnl ignored", 0, 2, 0, 1, 1, 0);
        fill(2, 0, 0, -50);
        fill(2, 0, 0, -50);
        order("R5 at limit", 0, 2, 0, 1, 1, 0);
        fill(2, 0, 0, -1);
        order("R5 over limit", 0, 2, 0, 1, 1, 0);
        order("R10 tick_min same cycle", 0, 2, 0, 1, 1, 1);
        order("R5 cleared", 0, 2, 0, 1, 1, 0);
        lim_minute_loss = '1;

        // R6: day total, boundary at exactly -limit
        lim_daily_loss = 8'd20;
        fill(3, 0, 0, -19);
        order("R6 at floor", 0, 3, 0, 1, 1, 1);
        fill(3, 0, 0, -1);
        order("R6 below floor", 0, 3, 0, 1, 1, 1);
        fill(3, 0, 0, 5);
        order("R6 recovered", 0, 3, 0, 1, 1, 1);
        lim_daily_loss = '1;

        // R7: rate counting; rejected orders not counted
        lim_rate = 3'd3;
        order("R7 rate", 0, 0, 0, 1, 1, 0);
        order("R7 rate", 0, 0, 0, 1, 0, 0);
        lim_order_qty = 4'd2;
        order("R7 size reject not counted", 0, 0, 0, 9, 0, 0);
        order("R7 rate third", 0, 0, 0, 1, 0, 0);
        order("R7 rate over", 0, 0, 0, 1, 0, 0);
        order("R10 tick_sec same cycle", 0, 0, 0, 1, 1, 0);
        lim_order_qty = '1;

        // R8: all checks fail, relax one at a time
        fill(1, 0, 15, -100); fill(1, 0, 15, -100);
        lim_rate = 3'd0; lim_daily_loss = 8'd10; lim_minute_loss = 8'd10;
        lim_position = 6'd5; lim_order_qty = 4'd3;
        order("R8 priority size", 0, 1, 0, 9, 0, 0);
        lim_order_qty = '1;
        order("R8 priority position", 0, 1, 0, 9, 0, 0);
        lim_position = '1;
        order("R8 priority minute", 0, 1, 0, 9, 0, 0);
        lim_minute_loss = '1;
        order("R8 priority day", 0, 1, 0, 9, 0, 0);
        lim_daily_loss = '1;
        order("R8 priority rate", 0, 1, 0, 9, 0, 0);
        lim_rate = '1;
        order("R8 all clear", 0, 1, 1, 9, 0, 0);

        // Mixed pseudo-random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            next_rng();
            if (n % 200 == 0) begin
                lim_order_qty   = QTY_W'(rng[3:0] | 4'd4);
                lim_position    = POS_W'(rng[9:4] | 6'd8);
                lim_minute_loss = PNL_W'(rng[17:10]);
                lim_daily_loss  = PNL_W'(rng[25:18] | 8'h40);
                lim_rate        = RATE_W'(rng[28:26]);
                next_rng();
            end
            step("R10 mixed traffic", rng[0], rng[1] & rng[2] & rng[3], int'(rng[5:4]), rng[6],
                 int'(rng[10:7]), rng[11] & rng[12], int'(rng[14:13]), rng[15], int'(rng[19:16]),
                 int'($signed(rng[27:20])), rng[28] & rng[29] & rng[30], (rng[31:26] == 6'd0));
        end
        report();
    end

endmodule